// File: doc/BRIEF.md
# Add/Subtract Unit with Condition Flags

This block adds or subtracts two unsigned/two's-complement operands and keeps four condition bits about the last recorded operation: carry, sign, zero and overflow. The arithmetic result is combinational and always reflects the present operands. The condition bits live in a register that is loaded on a rising clock edge only when the update enable is high, so a control unit can decide which operations leave a trace in the status.

Subtraction is carried out as an addition of the inverted subtrahend with a carry-in of one. A configuration input chooses how the carry bit is stored after a subtraction: either as the raw adder carry (1 when no borrow occurred) or inverted, as a borrow (1 when the first operand is unsigned-below the second). The asynchronous active-low reset is asserted at once and released through a two-stage synchronizer.

Top module: `alu_status_unit`

## Requirements
- R1: `result` is (opa + opb) mod 2^W when `sub_sel` is 0 and (opa - opb) mod 2^W when `sub_sel` is 1, combinationally, whatever `upd_en` is.
- R2: With `borrow_mode` 0, or on any addition, the stored carry `flag_c` is the carry out of the top bit of the adder; for a subtraction this is 1 when opa >= opb unsigned.
- R3: With `borrow_mode` 1, after a subtraction `flag_c` is 1 exactly when opa < opb unsigned; on an addition `borrow_mode` has no effect.
- R4: The stored sign `flag_s` is the top bit of the recorded result.
- R5: The stored zero `flag_z` is 1 only when every bit of the recorded result is 0.
- R6: The stored overflow `flag_v` is the XOR of the carry into and the carry out of the top bit, i.e. 1 when the signed result lies outside -2^(W-1)..2^(W-1)-1.
- R7: The four flags load on a rising clock edge only while `upd_en` is 1, and hold otherwise.
- R8: Reset (`rst_n` low) clears all four flags to 0; updates resume two clock edges after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| opa | input | W | First operand |
| opb | input | W | Second operand (subtrahend) |
| sub_sel | input | 1 | 0 = add, 1 = subtract |
| upd_en | input | 1 | Load the flags on the next rising edge |
| borrow_mode | input | 1 | 1 = store carry after subtraction as a borrow |
| result | output | W | Combinational sum or difference |
| flag_c | output | 1 | Stored carry/borrow |
| flag_s | output | 1 | Stored sign |
| flag_z | output | 1 | Stored zero |
| flag_v | output | 1 | Stored overflow |

## Verification
The result is due in the same cycle the operands are applied, so the bench checks it one nanosecond after driving inputs at the falling edge. The flags are due after exactly one rising edge with `upd_en` high; the bench updates its behavioural model at that edge and compares all four flags at the following falling edge, before new inputs are driven. Steps with `upd_en` low leave the model untouched, so any change in the flags is reported against R7.

// File: rtl/alu_flag_pkg.sv
package alu_flag_pkg;
  typedef struct packed {
    logic c;
    logic s;
    logic z;
    logic v;
  } cond_bits_t;
endpackage

// File: rtl/rst_sync.sv
module rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign srst_n = chain_q[STAGES-1];
endmodule

// File: rtl/ripple_adder.sv
module ripple_adder #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         c_into_msb,
  output logic         c_out
);
  logic [W:0] carry;

  assign carry[0] = cin;

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign sum[i]     = a[i] ^ b[i] ^ carry[i];
    assign carry[i+1] = (a[i] & b[i]) | (carry[i] & (a[i] ^ b[i]));
  end

  assign c_into_msb = carry[W-1];
  assign c_out      = carry[W];
endmodule

// File: rtl/flag_logic.sv
module flag_logic
  import alu_flag_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] sum,
  input  logic         c_into_msb,
  input  logic         c_out,
  input  logic         is_sub,
  input  logic         borrow_mode,
  output cond_bits_t   flags_nxt
);
  always_comb begin
    flags_nxt.c = (is_sub && borrow_mode) ? ~c_out : c_out;
    flags_nxt.s = sum[W-1];
    flags_nxt.z = ~|sum;
    flags_nxt.v = c_into_msb ^ c_out;
  end
endmodule

// File: rtl/status_reg.sv
module status_reg
  import alu_flag_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  cond_bits_t d,
  output cond_bits_t q
);
  cond_bits_t q_r;
  cond_bits_t q_nxt;

  always_comb begin
    q_nxt = q_r;
    if (en) q_nxt = d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_r <= '0;
    else        q_r <= q_nxt;
  end

  assign q = q_r;

  // R7
  hold_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(q_r));

  // R7
  load_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> q_r == $past(d));
endmodule

// File: rtl/alu_status_unit.sv
module alu_status_unit
  import alu_flag_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  input  logic         sub_sel,
  input  logic         upd_en,
  input  logic         borrow_mode,
  output logic [W-1:0] result,
  output logic         flag_c,
  output logic         flag_s,
  output logic         flag_z,
  output logic         flag_v
);
  logic         rst_q_n;
  logic [W-1:0] b_eff;
  logic         c_msb;
  logic         c_top;
  cond_bits_t   flags_nxt;
  cond_bits_t   flags_q;

  rst_sync #(.STAGES(2)) u_rst_sync (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (rst_q_n)
  );

  assign b_eff = sub_sel ? ~opb : opb;

  ripple_adder #(.W(W)) u_adder (
    .a          (opa),
    .b          (b_eff),
    .cin        (sub_sel),
    .sum        (result),
    .c_into_msb (c_msb),
    .c_out      (c_top)
  );

  flag_logic #(.W(W)) u_flags (
    .sum         (result),
    .c_into_msb  (c_msb),
    .c_out       (c_top),
    .is_sub      (sub_sel),
    .borrow_mode (borrow_mode),
    .flags_nxt   (flags_nxt)
  );

  status_reg u_status (
    .clk   (clk),
    .rst_n (rst_q_n),
    .en    (upd_en),
    .d     (flags_nxt),
    .q     (flags_q)
  );

  assign flag_c = flags_q.c;
  assign flag_s = flags_q.s;
  assign flag_z = flags_q.z;
  assign flag_v = flags_q.v;

  // R2
  add_carry_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (upd_en && !sub_sel) |=> flag_c == (({1'b0, $past(opa)} + {1'b0, $past(opb)}) >> W));

  // R3
  borrow_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (upd_en && sub_sel && borrow_mode) |=> flag_c == ($past(opa) < $past(opb)));

  // R4
  sign_flag_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    upd_en |=> flag_s == $past(result[W-1]));

  // R5
  zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    upd_en |=> flag_z == ($past(result) == '0));

  // R6
  add_overflow_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (upd_en && !sub_sel) |=> flag_v ==
      (($past(opa[W-1]) == $past(opb[W-1])) && ($past(result[W-1]) != $past(opa[W-1]))));
endmodule

// File: tb/alu_status_unit_tb.sv
`timescale 1ns/1ps
module alu_status_unit_tb;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [W-1:0] opa, opb;
  logic         sub_sel, upd_en, borrow_mode;
  logic [W-1:0] result;
  logic         flag_c, flag_s, flag_z, flag_v;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;
  bit prev_upd = 1'b1;

  // behavioural model of the stored flags
  bit m_c, m_s, m_z, m_v;

  always #4 clk = ~clk;

  alu_status_unit #(.W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .opa(opa), .opb(opb), .sub_sel(sub_sel),
    .upd_en(upd_en), .borrow_mode(borrow_mode), .result(result),
    .flag_c(flag_c), .flag_s(flag_s), .flag_z(flag_z), .flag_v(flag_v)
  );

  task automatic cmp(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d (a=%0d b=%0d sub=%0b bm=%0b)",
               tag, act, exp, opa, opb, sub_sel, borrow_mode);
    end
  endtask

  task automatic check_flags();
    string pre;
    pre = prev_upd ? "" : "R7 hold ";
    cmp({pre, "R2/R3 carry"}, flag_c, m_c);
    cmp({pre, "R4 sign"},     flag_s, m_s);
    cmp({pre, "R5 zero"},     flag_z, m_z);
    cmp({pre, "R6 overflow"}, flag_v, m_v);
  endtask

  task automatic step(input int a, input int b, input bit s, input bit u, input bit bm);
    int sum, res, cout, sa, sb, sres;
    @(negedge clk);
    check_flags();
    opa = a[W-1:0]; opb = b[W-1:0]; sub_sel = s; upd_en = u; borrow_mode = bm;
    sum  = s ? (a + (255 - b) + 1) : (a + b);
    res  = sum & 255;
    cout = (sum >> 8) & 1;
    sa   = (a > 127) ? a - 256 : a;
    sb   = (b > 127) ? b - 256 : b;
    sres = s ? sa - sb : sa + sb;
    #1;
    cmp("R1 result", result, res);
    @(posedge clk);
    if (u) begin
      m_c = (s && bm) ? !cout : cout;
      m_s = res > 127;
      m_z = res == 0;
      m_v = (sres > 127) || (sres < -128);
    end
    prev_upd = u;
  endtask

  initial begin
    #400000;
    if (!finished) begin
      n_bad++; n_cmp++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; opa = '0; opb = '0; sub_sel = 0; upd_en = 0; borrow_mode = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R8 reset state
    cmp("R8 reset c", flag_c, 0); cmp("R8 reset s", flag_s, 0);
    cmp("R8 reset z", flag_z, 0); cmp("R8 reset v", flag_v, 0);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    // directed corners
    step(8'h00, 8'h00, 0, 1, 0);   // R5 zero
    step(8'hFF, 8'h01, 0, 1, 0);   // R2 carry out, zero
    step(8'h7F, 8'h01, 0, 1, 0);   // R6 positive overflow, R4 sign
    step(8'h80, 8'h80, 0, 1, 1);   // R3 add ignores borrow mode; carry, overflow
    step(8'h80, 8'h01, 1, 1, 0);   // R6 subtract overflow
    step(8'h05, 8'h05, 1, 1, 0);   // R2 no borrow -> carry 1
    step(8'h05, 8'h05, 1, 1, 1);   // R3 borrow mode -> 0
    step(8'h03, 8'h05, 1, 1, 1);   // R3 a<b -> 1
    step(8'h03, 8'h05, 1, 1, 0);   // R2 a<b -> 0
    step(8'h00, 8'h00, 0, 0, 0);   // R7 hold, R1 result still driven
    step(8'h7F, 8'hFF, 1, 0, 1);   // R7 hold
    step(8'h40, 8'h40, 0, 1, 0);   // R6 overflow into sign
    step(8'h00, 8'h01, 1, 1, 1);   // R3 borrow at zero
    for (int i = 0; i < 400; i++)
      step($urandom_range(0, 255), $urandom_range(0, 255), $urandom_range(0, 1),
           $urandom_range(0, 3) != 0, $urandom_range(0, 1));
    // mid-run reset, R8
    @(negedge clk);
    check_flags();
    rst_n = 1'b0;
    #1;
    cmp("R8 async clear c", flag_c, 0); cmp("R8 async clear s", flag_s, 0);
    cmp("R8 async clear z", flag_z, 0); cmp("R8 async clear v", flag_v, 0);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule